// File: doc/BRIEF.md
# Multi-mode serial response compactor

This block reduces a serial stream of test-response bits to four compact figures, all computed in parallel: a count of bit-to-bit transitions, a count of ones, an accumulator that adds the running ones count after each bit, and a parity bit. Comparing the four figures against values from a known-good device shows whether the response differed. Because each mode forgets different information, a fault that one mode misses can still show up in another. For example, a double-bit error can keep the transitions, ones and parity unchanged while the accumulator moves.

A capture begins with a synchronous start pulse. The pulse clears all four figures and opens the stream input. Bits arrive on a valid/ready channel, and a bit counts only in a cycle where both valid and ready are high. Ready is low outside a capture and also once the compile-time maximum length has been taken, so the source must hold its bit until ready returns. An end pulse closes the capture. On that pulse the block latches the figures, including any bit accepted in the same cycle, and compares each figure against its expected input. One cycle later it shows the results with a single-cycle done pulse. The results and mismatch flags then stay unchanged until the next end pulse.

Top module: `resp_compactor`

## Requirements
- R1: After reset, in_ready and done_o are 0, and all results and mismatch flags are 0.
- R2: A start_i pulse clears the running figures, abandons any capture in progress, and drives in_ready to 1 in the next cycle. No bit is taken in the cycle of start_i.
- R3: A bit is counted only in a cycle where in_valid and in_ready are both 1. Bits presented with in_valid low, or while in_ready is low, change no result.
- R4: res_trans is the number of adjacent bit pairs whose values differ. The first bit of a capture adds nothing, so a capture of one bit or none gives 0.
- R5: res_ones is the number of accepted 1 bits.
- R6: res_acc is the sum, over every accepted position k, of the number of ones among the first k bits. Stream 1,1,0,0,1,0,0,0 (first bit first) gives 19, stream 1,0,0,1,1,0,0,0 gives 17, and stream 1,0,1,0,0,1,1,0 gives 19.
- R7: res_par is the XOR of all accepted bits.
- R8: An end_i pulse during a capture latches the results, including a bit accepted in that same cycle. done_o is 1 in exactly the following cycle, and in_ready is 0 from then until the next start_i. An end_i pulse outside a capture is ignored.
- R9: Each mismatch flag (mis_trans, mis_ones, mis_acc, mis_par) is 1 exactly when the latched figure for its mode differs from its expected input as sampled at the end_i cycle.
- R10: After MAX_LEN bits have been accepted, in_ready stays 0 and further valid bits are not counted until end_i or start_i.
- R11: Results and mismatch flags change only in the cycle in which done_o is 1. They are held across later captures until the next end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the figures and opens a capture |
| end_i | input | 1 | Closes the capture and latches the results |
| in_valid | input | 1 | Stream bit is present |
| in_ready | output | 1 | Block can take a stream bit |
| in_bit | input | 1 | Stream bit |
| exp_trans | input | CW | Expected transition count |
| exp_ones | input | CW | Expected ones count |
| exp_acc | input | AW | Expected accumulator value |
| exp_par | input | 1 | Expected parity |
| done_o | output | 1 | Single-cycle pulse when results are valid |
| res_trans | output | CW | Transition count |
| res_ones | output | CW | Ones count |
| res_acc | output | AW | Accumulator value |
| res_par | output | 1 | Parity |
| mis_trans | output | 1 | Transition count differs from expected |
| mis_ones | output | 1 | Ones count differs from expected |
| mis_acc | output | 1 | Accumulator differs from expected |
| mis_par | output | 1 | Parity differs from expected |

## Verification
Several properties are checked on every cycle: the done pulse lasts one cycle, ready is low while done is shown, and start always reopens the channel. The results and flags hold steady outside the done cycle. Parity agrees with the low bit of the ones count, and the accumulator never falls below the ones count. The exact values of the four figures, the double-bit error that only the accumulator catches, the accumulator aliasing case, the length cap and the rejection of gapped or out-of-capture bits can only be shown by the bench's scenarios. The bench compares each of those against a reference computed on its own.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic {
    RC_IDLE = 1'b0,
    RC_RUN  = 1'b1
  } rc_state_e;
endpackage

// File: rtl/rc_trans.sv
// Transition counter: remembers the previous bit and whether a bit was seen.
module rc_trans #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          bit_i,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] cnt_q;
  logic          prev_q;
  logic          seen_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (take && seen_q && (bit_i != prev_q)) cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_nxt;
      prev_q <= bit_i;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rc_ones_acc.sv
// Ones counter and prefix-sum accumulator.
module rc_ones_acc #(
  parameter int CW = 9,
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          bit_i,
  output logic [CW-1:0] ones_nxt,
  output logic [AW-1:0] acc_nxt
);
  logic [CW-1:0] ones_q;
  logic [AW-1:0] acc_q;

  always_comb begin
    ones_nxt = ones_q;
    acc_nxt  = acc_q;
    if (take) begin
      ones_nxt = ones_q + CW'(bit_i);
      acc_nxt  = acc_q + AW'(ones_nxt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      acc_q  <= '0;
    end else if (clr) begin
      ones_q <= '0;
      acc_q  <= '0;
    end else begin
      ones_q <= ones_nxt;
      acc_q  <= acc_nxt;
    end
  end
endmodule

// File: rtl/rc_parity.sv
// Single-stage modulo-2 compactor.
module rc_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic bit_i,
  output logic par_nxt
);
  logic par_q;

  assign par_nxt = par_q ^ (take & bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   par_q <= 1'b0;
    else if (clr) par_q <= 1'b0;
    else          par_q <= par_nxt;
  end
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
  import rc_pkg::*;
#(
  parameter  int MAX_LEN = 256,
  localparam int CW      = $clog2(MAX_LEN) + 1,
  localparam int AW      = 2 * $clog2(MAX_LEN) + 1,
  localparam int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          end_i,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  input  logic [CW-1:0] exp_trans,
  input  logic [CW-1:0] exp_ones,
  input  logic [AW-1:0] exp_acc,
  input  logic          exp_par,
  output logic          done_o,
  output logic [CW-1:0] res_trans,
  output logic [CW-1:0] res_ones,
  output logic [AW-1:0] res_acc,
  output logic          res_par,
  output logic          mis_trans,
  output logic          mis_ones,
  output logic          mis_acc,
  output logic          mis_par
);
  rc_state_e     state_q;
  logic [LW-1:0] len_q;
  logic          take;
  logic          fin;
  logic [CW-1:0] trans_nxt;
  logic [CW-1:0] ones_nxt;
  logic [AW-1:0] acc_nxt;
  logic          par_nxt;

  assign in_ready = (state_q == RC_RUN) && (len_q < LW'(MAX_LEN));
  assign take     = in_valid && in_ready && !start_i;
  assign fin      = end_i && (state_q == RC_RUN) && !start_i;

  rc_trans #(.CW(CW)) u_trans (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .take(take), .bit_i(in_bit),
    .cnt_nxt(trans_nxt)
  );

  rc_ones_acc #(.CW(CW), .AW(AW)) u_ones_acc (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .take(take), .bit_i(in_bit),
    .ones_nxt(ones_nxt), .acc_nxt(acc_nxt)
  );

  rc_parity u_par (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .take(take), .bit_i(in_bit),
    .par_nxt(par_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RC_IDLE;
      len_q   <= '0;
    end else if (start_i) begin
      state_q <= RC_RUN;
      len_q   <= '0;
    end else if (fin) begin
      state_q <= RC_IDLE;
    end else if (take) begin
      len_q   <= len_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      res_trans <= '0;
      res_ones  <= '0;
      res_acc   <= '0;
      res_par   <= 1'b0;
      mis_trans <= 1'b0;
      mis_ones  <= 1'b0;
      mis_acc   <= 1'b0;
      mis_par   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        res_trans <= trans_nxt;
        res_ones  <= ones_nxt;
        res_acc   <= acc_nxt;
        res_par   <= par_nxt;
        mis_trans <= (trans_nxt != exp_trans);
        mis_ones  <= (ones_nxt != exp_ones);
        mis_acc   <= (acc_nxt != exp_acc);
        mis_par   <= (par_nxt != exp_par);
      end
    end
  end
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
  parameter int CW = 9,
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          in_ready,
  input logic          done_o,
  input logic [CW-1:0] res_trans,
  input logic [CW-1:0] res_ones,
  input logic [AW-1:0] res_acc,
  input logic          res_par,
  input logic          mis_trans,
  input logic          mis_ones,
  input logic          mis_acc,
  input logic          mis_par
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready);

  // R2
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> in_ready);

  // R7
  par_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_par == res_ones[0]));

  // R6
  acc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_acc >= AW'(res_ones)));

  // R4
  trans_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_ones == '0) |-> (res_trans == '0));

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(res_trans) && $stable(res_ones) && $stable(res_acc) && $stable(res_par)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(mis_trans) && $stable(mis_ones) && $stable(mis_acc) && $stable(mis_par)));
endmodule

bind resp_compactor rc_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_ready(in_ready),
  .done_o(done_o), .res_trans(res_trans), .res_ones(res_ones),
  .res_acc(res_acc), .res_par(res_par), .mis_trans(mis_trans),
  .mis_ones(mis_ones), .mis_acc(mis_acc), .mis_par(mis_par)
);

// File: tb/resp_compactor_tb.sv
`timescale 1ns/1ps
module resp_compactor_tb;
  localparam int N  = 256;
  localparam int CW = $clog2(N) + 1;
  localparam int AW = 2 * $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, end_i = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, done_o;
  logic [CW-1:0] exp_trans = '0, exp_ones = '0, res_trans, res_ones;
  logic [AW-1:0] exp_acc = '0, res_acc;
  logic exp_par = 1'b0, res_par;
  logic mis_trans, mis_ones, mis_acc, mis_par;

  int tests = 0, fails = 0;
  logic [N-1:0] s;
  int unsigned seed = 32'd1234;

  always #10 clk = ~clk;

  resp_compactor #(.MAX_LEN(N)) u_dut (.*);

  function automatic int f_trans(input logic [N-1:0] v, input int n);
    int t = 0;
    for (int i = 1; i < n; i++) t += int'(v[i] ^ v[i-1]);
    return t;
  endfunction
  function automatic int f_ones(input logic [N-1:0] v, input int n);
    int t = 0;
    for (int i = 0; i < n; i++) t += int'(v[i]);
    return t;
  endfunction
  function automatic int f_acc(input logic [N-1:0] v, input int n);
    int t = 0, o = 0;
    for (int i = 0; i < n; i++) begin o += int'(v[i]); t += o; end
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_res(input int et, input int eo, input int ea, input int ep, input string tag);
    chk(int'(res_trans) == et, {"R4 ", tag}, int'(res_trans), et);
    chk(int'(res_ones) == eo, {"R5 ", tag}, int'(res_ones), eo);
    chk(int'(res_acc) == ea, {"R6 ", tag}, int'(res_acc), ea);
    chk(int'(res_par) == ep, {"R7 ", tag}, int'(res_par), ep);
  endtask

  // Runs one capture of s[0..n-1]; corrupt bits [3:0] = trans, ones, acc, par.
  task automatic run(input int n, input bit gaps, input bit same_end,
                     input logic [3:0] corrupt, input string tag);
    int et, eo, ea, ep;
    bit sent = 1'b0;
    et = f_trans(s, n); eo = f_ones(s, n); ea = f_acc(s, n); ep = eo % 2;
    exp_trans = CW'(et) ^ CW'(corrupt[3]);
    exp_ones  = CW'(eo) ^ CW'(corrupt[2]);
    exp_acc   = AW'(ea) ^ AW'(corrupt[1]);
    exp_par   = 1'(ep)  ^ corrupt[0];
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(in_ready == 1'b1, {"R2 ", tag}, int'(in_ready), 1);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0; in_bit = 1'b1;   // R3: not counted
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = s[i];
      if (same_end && i == n - 1) begin end_i = 1'b1; sent = 1'b1; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (!sent) begin end_i = 1'b1; @(negedge clk); end
    end_i = 1'b0;
    chk(done_o == 1'b1, {"R8 done ", tag}, int'(done_o), 1);
    chk(in_ready == 1'b0, {"R8 ready ", tag}, int'(in_ready), 0);
    chk_res(et, eo, ea, ep, tag);
    chk({mis_trans, mis_ones, mis_acc, mis_par} == corrupt, {"R9 ", tag},
        int'({mis_trans, mis_ones, mis_acc, mis_par}), int'(corrupt));
    @(negedge clk);
    chk(done_o == 1'b0, {"R8 pulse ", tag}, int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0 && done_o == 1'b0, "R1 ctrl", int'({in_ready, done_o}), 0);
    chk(res_trans == '0 && res_ones == '0 && res_acc == '0 && res_par == 1'b0, "R1 res",
        int'(res_acc), 0);
    chk({mis_trans, mis_ones, mis_acc, mis_par} == 4'b0, "R1 flags",
        int'({mis_trans, mis_ones, mis_acc, mis_par}), 0);
    rst_n = 1'b1;

    // R6 directed streams (s[0] first)
    s = '0; s[7:0] = 8'b0001_0011; run(8, 1'b0, 1'b1, 4'b0000, "good 19");
    s = '0; s[7:0] = 8'b0001_1001; run(8, 1'b0, 1'b0, 4'b0000, "double err 17");
    s = '0; s[7:0] = 8'b0110_0101; run(8, 1'b1, 1'b1, 4'b0000, "alias 19");
    // R9: double-bit error against good expectations -> only acc flag
    s = '0; s[7:0] = 8'b0001_1001;
    exp_trans = CW'(3); exp_ones = CW'(3); exp_acc = AW'(19); exp_par = 1'b1;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_bit = s[i]; end_i = (i == 7); @(negedge clk);
    end
    in_valid = 1'b0; end_i = 1'b0;
    chk({mis_trans, mis_ones, mis_acc, mis_par} == 4'b0010, "R9 only acc",
        int'({mis_trans, mis_ones, mis_acc, mis_par}), 2);
    @(negedge clk);

    // R4 empty and single-bit captures
    s = '0; run(0, 1'b0, 1'b0, 4'b0000, "empty");
    s = '0; s[0] = 1'b1; run(1, 1'b0, 1'b1, 4'b0000, "single");

    // R3 R11: bits while idle and end outside capture change nothing
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_bit = 1'b1; end_i = (i == 2); @(negedge clk);
      chk(in_ready == 1'b0, "R3 idle ready", int'(in_ready), 0);
    end
    in_valid = 1'b0; end_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R8 idle end", int'(done_o), 0);
    chk_res(0, 1, 1, 1, "R11 held");

    // R2 restart mid-capture: only the later stream counts
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin in_valid = 1'b1; in_bit = 1'b1; @(negedge clk); end
    in_valid = 1'b0;
    s = '0; s[3:0] = 4'b0110; run(4, 1'b0, 1'b0, 4'b0000, "R2 restart");

    // R10 length cap
    s = '1;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < N; i++) begin in_valid = 1'b1; in_bit = 1'b1; @(negedge clk); end
    chk(in_ready == 1'b0, "R10 cap ready", int'(in_ready), 0);
    repeat (3) @(negedge clk);   // valid held high, ignored
    in_valid = 1'b0; end_i = 1'b1; @(negedge clk); end_i = 1'b0;
    chk(int'(res_ones) == N, "R10 ones", int'(res_ones), N);
    chk(int'(res_acc) == N * (N + 1) / 2, "R10 acc", int'(res_acc), N * (N + 1) / 2);
    chk(res_trans == '0, "R10 trans", int'(res_trans), 0);
    @(negedge clk);

    // random captures
    for (int k = 0; k < 30; k++) begin
      int n;
      n = 1 + int'($urandom % 60);
      s = '0;
      for (int i = 0; i < n; i++) s[i] = 1'($urandom);
      run(n, 1'($urandom), 1'($urandom), 4'($urandom), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule